// File: doc/BRIEF.md
# Host Bus Interface with Data Acknowledge

This block sits between a microprocessor bus and a register file. The host side uses active-low chip enable, read, write and interrupt-acknowledge strobes. The block brings these strobes into the internal clock domain through a synchronizer and turns them into single-cycle internal pulses: a register write, a read side effect such as a FIFO pop, and an interrupt-acknowledge event. It drives two open-drain-style outputs, modelled as pull-low enables: the data acknowledge and the interrupt request.

Two kinds of host can be attached. A host that waits for a handshake watches the data acknowledge. It is pulled low a fixed number of clocks after a strobe is recognized and released once chip enable (or interrupt acknowledge) returns high. In that mode a register write commits on the same edge on which the acknowledge is pulled low. A host that runs without a handshake needs none of this. For such a host the handshake can be switched off by a write to a dedicated address, after which writes commit when the write strobe is released. A write to a second address switches the handshake back on, and reset leaves it on.

A read only triggers its side effect if the strobe was held for a minimum number of clocks. A short read, such as the one some bus adapters produce when a write ends while chip enable is still low, therefore cannot move a FIFO pointer.

Top module: `hbi_bridge`

## Requirements
- R1: After reset, ack_pull, irq_pull, reg_wr, reg_rd and reg_iack are all 0, and the handshake is enabled.
- R2: With the handshake enabled, a read, write or interrupt-acknowledge strobe held for more than ACK_DLY clocks gives ack_pull = 1 exactly SYNC_STAGES+ACK_DLY+1 clocks after the strobe falls. ack_pull stays 1 until chip enable and interrupt acknowledge are both high again, and returns to 0 SYNC_STAGES+1 clocks after that.
- R3: With the handshake enabled and the write strobe held for more than ACK_DLY clocks, reg_wr pulses for one clock in the same cycle in which ack_pull rises. reg_waddr and reg_wdata carry the address and data that were present when the strobe fell.
- R4: With the handshake disabled, ack_pull never rises, and a write pulses reg_wr for one clock SYNC_STAGES+1 clocks after the write strobe rises.
- R5: A write to address 0x26 disables the handshake and a write to 0x27 enables it. Neither write produces a reg_wr pulse.
- R6: A read strobe held for at least MIN_RD_CLKS clocks (2 by default) pulses reg_rd once, SYNC_STAGES+1 clocks after the strobe rises. reg_raddr carries the read address.
- R7: A read strobe shorter than MIN_RD_CLKS clocks, including one that appears just after a write while chip enable stays low, produces no reg_rd pulse.
- R8: With the handshake enabled, a write strobe released before the acknowledge is due still commits once, SYNC_STAGES+1 clocks after release, and ack_pull stays 0.
- R9: An interrupt-acknowledge strobe pulses reg_iack for one clock, SYNC_STAGES+1 clocks after it falls.
- R10: irq_pull equals int_req delayed by one clock.
- R11: bus_rdata_oe is 1 while chip enable and read are both low, or while interrupt acknowledge is low, and bus_rdata equals reg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip enable, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| iack_n | input | 1 | Host interrupt acknowledge, active low |
| addr | input | AW | Host address |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Data returned to the host |
| bus_rdata_oe | output | 1 | Host data bus drive enable |
| ack_pull | output | 1 | 1 pulls the data acknowledge line low |
| irq_pull | output | 1 | 1 pulls the interrupt request line low |
| int_req | input | 1 | Interrupt request from internal logic |
| reg_rdata | input | DW | Read data from the register file |
| reg_waddr | output | AW | Register write address |
| reg_wdata | output | DW | Register write data |
| reg_wr | output | 1 | One-clock register write pulse |
| reg_raddr | output | AW | Register read address |
| reg_rd | output | 1 | One-clock read side-effect pulse |
| reg_iack | output | 1 | One-clock interrupt-acknowledge pulse |

## Verification
The assertions check these relations on every cycle:
- the acknowledge rises only while the handshake is enabled, and it drops once the synchronized chip enable is high;
- a handshake-mode commit taken while the write strobe is still held is followed by the acknowledge;
- writes to the mode addresses never reach reg_wr;
- a read pulse only follows a strobe held for two clocks;
- the interrupt output tracks its input.

Only the bench scenarios can show the exact cycle counts from the host pins through the synchronizer, the mode switching across a sequence of writes, the fallback commit of an early-released write, and the suppression of the short read after a write.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  // Counter type shared by the strobe and acknowledge timers.
  typedef logic [7:0] cnt_t;

  // Saturating count while run is high, cleared when it is low.
  function automatic cnt_t cnt_step(cnt_t c, logic run);
    if (!run) return '0;
    return (c == '1) ? c : c + 8'd1;
  endfunction

  // True once the count has reached lim.
  function automatic logic cnt_reached(cnt_t c, int unsigned lim);
    return 32'(c) >= lim;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Idle level of every active-low strobe is 1.
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '1;
        else        stg <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '1;
        else        stg <= {stg[STAGES-2:0], d};
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbi_strobe_trk.sv
module hbi_strobe_trk
  import hbi_pkg::*;
#(
  parameter int unsigned MIN_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic start,
  output logic done
);
  logic prev;
  cnt_t cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= act;
      cnt  <= cnt_step(cnt, act);
    end

  assign start = act & ~prev;
  // End of a strobe that lasted long enough.
  assign done  = prev & ~act & cnt_reached(cnt, MIN_CLKS);
endmodule

// File: rtl/hbi_ack_ctl.sv
module hbi_ack_ctl
  import hbi_pkg::*;
#(
  parameter int unsigned DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_act,
  input  logic hold,
  input  logic en,
  output logic due,
  output logic ack
);
  cnt_t cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_step(cnt, acc_act);

  assign due = acc_act & (cnt == cnt_t'(DLY));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ack <= 1'b0;
    else if (!hold)    ack <= 1'b0;
    else if (due & en) ack <= 1'b1;
endmodule

// File: rtl/hbi_bridge.sv
module hbi_bridge
  import hbi_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ACK_DLY     = 2,
  parameter int unsigned MIN_RD_CLKS = 2,
  parameter logic [AW-1:0] HS_ON_ADDR  = AW'('h27),
  parameter logic [AW-1:0] HS_OFF_ADDR = AW'('h26)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          iack_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rdata_oe,
  output logic          ack_pull,
  output logic          irq_pull,
  input  logic          int_req,
  input  logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] reg_waddr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic [AW-1:0] reg_raddr,
  output logic          reg_rd,
  output logic          reg_iack
);
  localparam int unsigned NSTRB = 4;

  // Synchronized strobes, turned active high.
  logic [NSTRB-1:0] raw_n, syn_n;
  assign raw_n = {iack_n, wr_n, rd_n, cs_n};

  hbi_sync #(.W(NSTRB), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(syn_n)
  );

  logic cs_on, rd_act, wr_act, ia_act;
  assign cs_on  = ~syn_n[0];
  assign rd_act = cs_on & ~syn_n[1];
  assign wr_act = cs_on & ~syn_n[2];
  assign ia_act = ~syn_n[3];

  // Read and write strobe tracking.
  logic rd_start, rd_pop, wr_start, wr_done;

  hbi_strobe_trk #(.MIN_CLKS(MIN_RD_CLKS)) u_rd_trk (
    .clk(clk), .rst_n(rst_n), .act(rd_act), .start(rd_start), .done(rd_pop)
  );
  hbi_strobe_trk #(.MIN_CLKS(0)) u_wr_trk (
    .clk(clk), .rst_n(rst_n), .act(wr_act), .start(wr_start), .done(wr_done)
  );

  logic ia_prev, ia_start;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ia_prev <= 1'b0;
    else        ia_prev <= ia_act;
  assign ia_start = ia_act & ~ia_prev;

  // Data acknowledge timing.
  logic hs_en, acc_act, acc_hold, ack_due;
  assign acc_act  = rd_act | wr_act | ia_act;
  assign acc_hold = cs_on | ia_act;

  hbi_ack_ctl #(.DLY(ACK_DLY)) u_ack (
    .clk(clk), .rst_n(rst_n), .acc_act(acc_act), .hold(acc_hold),
    .en(hs_en), .due(ack_due), .ack(ack_pull)
  );

  // Write capture and commit.
  logic          wr_pend;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;
  logic          wr_commit, ctrl_hit;

  assign ctrl_hit  = (wr_addr_q == HS_ON_ADDR) | (wr_addr_q == HS_OFF_ADDR);
  assign wr_commit = wr_pend & ((hs_en & ack_due) | wr_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_pend   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      hs_en     <= 1'b1;
    end else begin
      if (wr_commit) begin
        wr_pend <= 1'b0;
        if (wr_addr_q == HS_ON_ADDR)  hs_en <= 1'b1;
        if (wr_addr_q == HS_OFF_ADDR) hs_en <= 1'b0;
      end
      if (wr_start) begin
        wr_pend   <= 1'b1;
        wr_addr_q <= addr;
        wr_data_q <= bus_wdata;
      end
    end

  // Registered internal strobes.
  logic [AW-1:0] rd_addr_q;
  logic          reg_wr_q, reg_rd_q, reg_iack_q, irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_addr_q  <= '0;
      reg_wr_q   <= 1'b0;
      reg_rd_q   <= 1'b0;
      reg_iack_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (rd_start | ia_start) rd_addr_q <= addr;
      reg_wr_q   <= wr_commit & ~ctrl_hit;
      reg_rd_q   <= rd_pop;
      reg_iack_q <= ia_start;
      irq_q      <= int_req;
    end

  assign reg_waddr    = wr_addr_q;
  assign reg_wdata    = wr_data_q;
  assign reg_wr       = reg_wr_q;
  assign reg_raddr    = rd_addr_q;
  assign reg_rd       = reg_rd_q;
  assign reg_iack     = reg_iack_q;
  assign irq_pull     = irq_q;
  assign bus_rdata    = reg_rdata;
  assign bus_rdata_oe = (~cs_n & ~rd_n) | ~iack_n;
endmodule

// File: rtl/hbi_bridge_chk.sv
module hbi_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic ack_pull,
  input logic hs_en,
  input logic cs_on,
  input logic ia_act,
  input logic wr_commit,
  input logic wr_act,
  input logic ctrl_hit,
  input logic reg_wr,
  input logic reg_rd,
  input logic rd_pop,
  input logic rd_act,
  input logic irq_pull,
  input logic int_req
);
  // R2
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_on && !ia_act) |=> !ack_pull);

  // R4
  ack_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> $past(hs_en));

  // R3
  wr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && hs_en && wr_act) |=> ack_pull);

  // R5
  ctrl_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && ctrl_hit) |=> !reg_wr);

  // R6
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R7
  rd_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> ($past(rd_act) && $past(rd_act, 2)));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_pull == $past(int_req)));
endmodule

bind hbi_bridge hbi_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_pull(ack_pull), .hs_en(hs_en),
  .cs_on(cs_on), .ia_act(ia_act), .wr_commit(wr_commit), .wr_act(wr_act),
  .ctrl_hit(ctrl_hit), .reg_wr(reg_wr), .reg_rd(reg_rd), .rd_pop(rd_pop),
  .rd_act(rd_act), .irq_pull(irq_pull), .int_req(int_req)
);

// File: tb/hbi_bridge_tb.sv
module hbi_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int DLY  = 2;
  localparam int MINR = 2;
  localparam int BIG  = 32'h7fffffff;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, iack_n = 1, int_req = 0;
  logic [7:0] addr = 0, bus_wdata = 0, reg_rdata = 0;
  logic [7:0] bus_rdata, reg_waddr, reg_wdata, reg_raddr;
  logic bus_rdata_oe, ack_pull, irq_pull, reg_wr, reg_rd, reg_iack;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbi_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .iack_n(iack_n), .addr(addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .ack_pull(ack_pull), .irq_pull(irq_pull),
    .int_req(int_req), .reg_rdata(reg_rdata), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_raddr(reg_raddr),
    .reg_rd(reg_rd), .reg_iack(reg_iack)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit run = 0, hs_mode = 1, finished = 0;
  logic irq_prev = 0;
  string req = "R1";
  int wr_at[$], rd_at[$], ia_at[$];
  logic [7:0] wa[$], wd[$], ra[$];
  int ack_on = BIG, ack_off = BIG;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    irq_prev <= int_req;
  end

  task automatic check(input bit ok, input string r, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  // Reference model compared every clock.
  bit ew, er, ei, ea;
  always @(negedge clk) if (rst_n && run) begin
    ew = (wr_at.size() > 0) && (wr_at[0] == cyc);
    check(reg_wr == ew, req, "reg_wr", reg_wr, ew);
    if (ew) begin
      check(reg_waddr == wa[0], req, "reg_waddr", reg_waddr, wa[0]);
      check(reg_wdata == wd[0], req, "reg_wdata", reg_wdata, wd[0]);
      void'(wr_at.pop_front()); void'(wa.pop_front()); void'(wd.pop_front());
    end
    er = (rd_at.size() > 0) && (rd_at[0] == cyc);
    check(reg_rd == er, req, "reg_rd", reg_rd, er);
    if (er) begin
      check(reg_raddr == ra[0], req, "reg_raddr", reg_raddr, ra[0]);
      void'(rd_at.pop_front()); void'(ra.pop_front());
    end
    ei = (ia_at.size() > 0) && (ia_at[0] == cyc);
    check(reg_iack == ei, "R9", "reg_iack", reg_iack, ei);
    if (ei) void'(ia_at.pop_front());
    ea = (cyc >= ack_on) && (cyc < ack_off);
    check(ack_pull == ea, req, "ack_pull", ack_pull, ea);
    check(irq_pull == irq_prev, "R10", "irq_pull", irq_pull, irq_prev);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                          input int hold, input int tail, input bit glitch);
    int c0; bit ctrl, ackx;
    @(negedge clk);
    c0 = cyc;
    cs_n = 0; wr_n = 0; addr = a; bus_wdata = d;
    ctrl = (a == 8'h27) || (a == 8'h26);
    ackx = hs_mode && (hold > DLY);
    ack_on = ackx ? c0 + SYNC + DLY + 1 : BIG;
    ack_off = BIG;
    if (!ctrl) begin
      wr_at.push_back(ackx ? c0 + SYNC + DLY + 1 : c0 + hold + SYNC + 1);
      wa.push_back(a); wd.push_back(d);
    end
    idle(hold);
    wr_n = 1;
    if (glitch) rd_n = 0;
    @(negedge clk);
    rd_n = 1;
    idle(tail - 1);
    cs_n = 1;
    if (ackx) ack_off = cyc + SYNC + 1;
    idle(6);
    if (ctrl) hs_mode = (a == 8'h27);
  endtask

  task automatic do_read(input logic [7:0] a, input int hold, input int tail,
                         input logic [7:0] v);
    int c0; bit ackx;
    @(negedge clk);
    c0 = cyc;
    cs_n = 0; rd_n = 0; addr = a; reg_rdata = v;
    ackx = hs_mode && (hold > DLY);
    ack_on = ackx ? c0 + SYNC + DLY + 1 : BIG;
    ack_off = BIG;
    if (hold >= MINR) begin
      rd_at.push_back(c0 + hold + SYNC + 1);
      ra.push_back(a);
    end
    #1;
    // R11: drive enable and data pass-through during a read
    check(bus_rdata_oe == 1'b1, "R11", "bus_rdata_oe", bus_rdata_oe, 1);
    check(bus_rdata == v, "R11", "bus_rdata", bus_rdata, v);
    idle(hold);
    rd_n = 1;
    idle(tail);
    cs_n = 1;
    if (ackx) ack_off = cyc + SYNC + 1;
    #1;
    check(bus_rdata_oe == 1'b0, "R11", "bus_rdata_oe idle", bus_rdata_oe, 0);
    idle(6);
  endtask

  task automatic do_iack(input int hold);
    int c0; bit ackx;
    @(negedge clk);
    c0 = cyc;
    iack_n = 0;
    ackx = hs_mode && (hold > DLY);
    ack_on = ackx ? c0 + SYNC + DLY + 1 : BIG;
    ack_off = BIG;
    ia_at.push_back(c0 + SYNC + 1);
    #1;
    check(bus_rdata_oe == 1'b1, "R11", "bus_rdata_oe iack", bus_rdata_oe, 1);
    idle(hold);
    iack_n = 1;
    if (ackx) ack_off = cyc + SYNC + 1;
    idle(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(ack_pull == 0, "R1", "ack_pull in reset", ack_pull, 0);
    check(reg_wr == 0 && reg_rd == 0 && reg_iack == 0, "R1", "strobes in reset",
          {reg_wr, reg_rd, reg_iack}, 0);
    check(irq_pull == 0, "R1", "irq_pull in reset", irq_pull, 0);
    rst_n = 1;
    run = 1;
    idle(3);
    // R1 and R3: handshake on after reset, write commits with the acknowledge
    req = "R3"; do_write(8'h10, 8'hA5, 5, 2, 0);
    // R2 and R6: long read gives acknowledge and one pop
    req = "R2"; do_read(8'h11, 5, 2, 8'h3C);
    req = "R6"; do_read(8'h12, 2, 2, 8'h5A);
    // R7: read of one clock pops nothing
    req = "R7"; do_read(8'h13, 1, 2, 8'h77);
    req = "R7"; do_write(8'h14, 8'h81, 5, 3, 1);
    // R8: early release still commits once, no acknowledge
    req = "R8"; do_write(8'h15, 8'h42, 1, 2, 0);
    // R9 and R10
    req = "R9"; int_req = 1; do_iack(5);
    int_req = 0; idle(2); int_req = 1; idle(1); int_req = 0;
    // R5: turn the handshake off
    req = "R5"; do_write(8'h26, 8'hFF, 5, 2, 0);
    // R4: no acknowledge, commit on strobe release
    req = "R4"; do_read(8'h16, 5, 2, 8'h99);
    req = "R4"; do_write(8'h20, 8'h0F, 3, 2, 0);
    req = "R7"; do_write(8'h21, 8'hF0, 4, 3, 1);
    req = "R4"; do_iack(5);
    // R5: turn it back on, then check the acknowledge returns
    req = "R5"; do_write(8'h27, 8'h00, 4, 2, 0);
    req = "R5"; do_write(8'h22, 8'h66, 6, 2, 0);
    idle(4);
    check(wr_at.size() == 0 && rd_at.size() == 0 && ia_at.size() == 0, "R3",
          "pending expected pulses", wr_at.size() + rd_at.size() + ia_at.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired in %s", req);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule